// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the arithmetic and logic stage of a 32-bit integer datapath. It takes two operands, where the second one has already passed through the shifter or comes from an immediate field. It also takes the current condition flags, a carry from the shifter, a 4-bit operation code and a flag-update enable. In the same cycle it returns the result, a result-write enable for the register file, and the next value of the four condition flags.

All subtractions share one adder. The adder always adds, and a subtraction is formed by inverting one operand and choosing the carry-in. So the carry flag after a subtraction means "no borrow occurred". The two compare operations only update the flags and never request a register write.

The block is purely combinational. Any registering is left to the pipeline around it. A generate option selects how the zero detector is built: a flat reduction, or a chunked tree.

Top module: `dpalu_top`

## Requirements
- R1: Code 3 (add) returns opa+opb. Code 4 (add with carry) returns opa+opb+C, where C is the incoming carry flag.
- R2: Code 5 (subtract with carry) returns opa-opb-(1-C).
- R3: Code 2 (reverse subtract) returns opb-opa. Code 6 (reverse subtract with carry) returns opb-opa-(1-C).
- R4: The logical codes return the following:
  - code 0: opa AND opb
  - code 9: opa OR opb
  - code 1: opa XOR opb
  - code 11: opa AND NOT opb
- R5: Code 10 (move) returns opb. Code 12 (move-not) returns NOT opb.
- R6: Code 7 (compare) sets the flags from opa-opb, and code 8 (compare-negative) sets them from opa+opb. Both keep the write enable low and update the flags even when the flag enable is low. The compare value appears on the result port.
- R7: The flag vector is ordered N,Z,C,V, at bit positions 3,2,1,0. For a non-compare code, the flags output equals the flags input unless the flag enable is high.
- R8: When the flags are updated, N equals result bit 31 and Z is set exactly when the 32-bit result is zero.
- R9: For the arithmetic codes, C is the adder carry-out, which means no borrow for a subtraction. V is set on two's-complement overflow.
- R10: For the logical and move codes, an update takes C from the shifter-carry input and keeps V from the flags input.
- R11: Codes 13 to 15 are reserved. They drive a zero result and a low write enable, and they pass the flags through unchanged.
- R12: The write enable is high for every code from 0 to 12 except 7 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand, already shifted or taken from an immediate |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| shift_carry_i | input | 1 | Carry produced by the operand shifter |
| op_sel_i | input | 4 | Operation code |
| set_flags_i | input | 1 | Flag update enable for non-compare codes |
| result_o | output | 32 | Operation result |
| wr_en_o | output | 1 | Request to write the result to the register file |
| flags_o | output | 4 | Next flags {N,Z,C,V} |

## Verification
The hardest cases to reach are the boundaries of the borrow convention. Examples are a subtract with carry where the incoming C is clear, so one extra unit is taken away, and a reverse subtract with carry whose adder still produces a carry-out. Signed overflow at the most negative value is also hard to reach. The vector table places operands right at these edges: 0x7FFFFFFF+1, 0x80000000-1 and 0x80000000+0x80000000. A walking-one sweep of a single set bit checks every chunk of the zero detector and the N bit, and a pass over all sixteen codes with the flag enable low checks the write enable and the flag hold.

// File: rtl/dpalu_pkg.sv
package dpalu_pkg;

   localparam int OP_W   = 4;
   localparam int FLAG_W = 4;
   localparam int FLAG_N = 3;
   localparam int FLAG_Z = 2;
   localparam int FLAG_C = 1;
   localparam int FLAG_V = 0;

   typedef enum logic [OP_W-1:0] {
      OP_AND = 4'd0,
      OP_XOR = 4'd1,
      OP_RSB = 4'd2,
      OP_ADD = 4'd3,
      OP_ADC = 4'd4,
      OP_SBC = 4'd5,
      OP_RSC = 4'd6,
      OP_CMP = 4'd7,
      OP_CMN = 4'd8,
      OP_ORR = 4'd9,
      OP_MOV = 4'd10,
      OP_BIC = 4'd11,
      OP_MVN = 4'd12,
      OP_RS0 = 4'd13,
      OP_RS1 = 4'd14,
      OP_RS2 = 4'd15
   } alu_op_e;

   typedef enum logic [1:0] {
      CIN_ZERO  = 2'd0,
      CIN_ONE   = 2'd1,
      CIN_CARRY = 2'd2
   } cin_sel_e;

   typedef struct packed {
      logic     is_arith;
      logic     is_logic;
      logic     is_cmp;
      logic     wr_en;
      logic     swap;
      logic     inv_y;
      cin_sel_e cin_sel;
   } alu_ctrl_t;

endpackage

// File: rtl/dpalu_decode.sv
module dpalu_decode
   import dpalu_pkg::*;
(
   input  logic [OP_W-1:0] op_i,
   output alu_ctrl_t       ctrl_o
);
   alu_op_e op;
   assign op = alu_op_e'(op_i);

   always_comb begin
      ctrl_o = '{is_arith: 1'b0, is_logic: 1'b0, is_cmp: 1'b0, wr_en: 1'b0,
                 swap: 1'b0, inv_y: 1'b0, cin_sel: CIN_ZERO};
      unique case (op)
         OP_ADD: begin ctrl_o.is_arith = 1'b1; ctrl_o.wr_en = 1'b1; end
         OP_ADC: begin
            ctrl_o.is_arith = 1'b1; ctrl_o.wr_en = 1'b1; ctrl_o.cin_sel = CIN_CARRY;
         end
         OP_SBC: begin
            ctrl_o.is_arith = 1'b1; ctrl_o.wr_en = 1'b1;
            ctrl_o.inv_y = 1'b1; ctrl_o.cin_sel = CIN_CARRY;
         end
         OP_RSB: begin
            ctrl_o.is_arith = 1'b1; ctrl_o.wr_en = 1'b1; ctrl_o.swap = 1'b1;
            ctrl_o.inv_y = 1'b1; ctrl_o.cin_sel = CIN_ONE;
         end
         OP_RSC: begin
            ctrl_o.is_arith = 1'b1; ctrl_o.wr_en = 1'b1; ctrl_o.swap = 1'b1;
            ctrl_o.inv_y = 1'b1; ctrl_o.cin_sel = CIN_CARRY;
         end
         OP_CMP: begin
            ctrl_o.is_arith = 1'b1; ctrl_o.is_cmp = 1'b1;
            ctrl_o.inv_y = 1'b1; ctrl_o.cin_sel = CIN_ONE;
         end
         OP_CMN: begin ctrl_o.is_arith = 1'b1; ctrl_o.is_cmp = 1'b1; end
         OP_AND, OP_XOR, OP_ORR, OP_BIC, OP_MOV, OP_MVN: begin
            ctrl_o.is_logic = 1'b1; ctrl_o.wr_en = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/dpalu_adder.sv
module dpalu_adder #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] x_i,
   input  logic [WIDTH-1:0] y_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o,
   output logic             ovf_o
);
   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("dpalu_adder: WIDTH must be at least 2");
   end

   logic [WIDTH:0] full;

   always_comb begin
      full   = {1'b0, x_i} + {1'b0, y_i} + {{WIDTH{1'b0}}, cin_i};
      sum_o  = full[MSB:0];
      cout_o = full[WIDTH];
      ovf_o  = (x_i[MSB] == y_i[MSB]) && (full[MSB] != x_i[MSB]);
   end
endmodule

// File: rtl/dpalu_logic.sv
module dpalu_logic
   import dpalu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [OP_W-1:0]  op_i,
   output logic [WIDTH-1:0] res_o
);
   alu_op_e op;
   assign op = alu_op_e'(op_i);

   always_comb begin
      unique case (op)
         OP_AND:  res_o = a_i & b_i;
         OP_ORR:  res_o = a_i | b_i;
         OP_XOR:  res_o = a_i ^ b_i;
         OP_BIC:  res_o = a_i & ~b_i;
         OP_MOV:  res_o = b_i;
         OP_MVN:  res_o = ~b_i;
         default: res_o = '0;
      endcase
   end
endmodule

// File: rtl/dpalu_flags.sv
module dpalu_flags
   import dpalu_pkg::*;
#(
   parameter int WIDTH      = 32,
   parameter bit ZERO_TREE  = 1'b1,
   parameter int ZERO_CHUNK = 8
) (
   input  logic [WIDTH-1:0]  res_i,
   input  logic              update_i,
   input  logic              arith_i,
   input  logic              cout_i,
   input  logic              ovf_i,
   input  logic              shift_carry_i,
   input  logic [FLAG_W-1:0] flags_i,
   output logic [FLAG_W-1:0] flags_o
);
   localparam int N_CHUNK = WIDTH / ZERO_CHUNK;

   logic is_zero;

   if (ZERO_TREE) begin : g_zero_tree
      if (ZERO_CHUNK < 1 || (WIDTH % ZERO_CHUNK) != 0) begin : g_bad_chunk
         $error("dpalu_flags: ZERO_CHUNK must divide WIDTH");
      end
      logic [N_CHUNK-1:0] chunk_any;
      for (genvar k = 0; k < N_CHUNK; k++) begin : g_chunk
         assign chunk_any[k] = |res_i[k*ZERO_CHUNK +: ZERO_CHUNK];
      end
      assign is_zero = ~|chunk_any;
   end else begin : g_zero_flat
      assign is_zero = ~|res_i;
   end

   logic [FLAG_W-1:0] fresh;
   always_comb begin
      fresh         = '0;
      fresh[FLAG_N] = res_i[WIDTH-1];
      fresh[FLAG_Z] = is_zero;
      fresh[FLAG_C] = arith_i ? cout_i : shift_carry_i;
      fresh[FLAG_V] = arith_i ? ovf_i  : flags_i[FLAG_V];
      flags_o       = update_i ? fresh : flags_i;
   end
endmodule

// File: rtl/dpalu_top.sv
module dpalu_top
   import dpalu_pkg::*;
#(
   parameter int WIDTH      = 32,
   parameter bit ZERO_TREE  = 1'b1,
   parameter int ZERO_CHUNK = 8
) (
   input  logic [WIDTH-1:0]  opa_i,
   input  logic [WIDTH-1:0]  opb_i,
   input  logic [FLAG_W-1:0] flags_i,
   input  logic              shift_carry_i,
   input  logic [OP_W-1:0]   op_sel_i,
   input  logic              set_flags_i,
   output logic [WIDTH-1:0]  result_o,
   output logic              wr_en_o,
   output logic [FLAG_W-1:0] flags_o
);
   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("dpalu_top: WIDTH must be at least 2");
   end

   alu_ctrl_t        ctrl;
   logic [WIDTH-1:0] add_x, add_y, add_sum, logic_res;
   logic             add_cin, add_cout, add_ovf, update;

   dpalu_decode u_decode (
      .op_i   (op_sel_i),
      .ctrl_o (ctrl)
   );

   always_comb begin
      add_x = ctrl.swap ? opb_i : opa_i;
      add_y = ctrl.swap ? opa_i : opb_i;
      if (ctrl.inv_y) add_y = ~add_y;
      unique case (ctrl.cin_sel)
         CIN_ONE:   add_cin = 1'b1;
         CIN_CARRY: add_cin = flags_i[FLAG_C];
         default:   add_cin = 1'b0;
      endcase
   end

   dpalu_adder #(.WIDTH(WIDTH)) u_adder (
      .x_i    (add_x),
      .y_i    (add_y),
      .cin_i  (add_cin),
      .sum_o  (add_sum),
      .cout_o (add_cout),
      .ovf_o  (add_ovf)
   );

   dpalu_logic #(.WIDTH(WIDTH)) u_logic (
      .a_i   (opa_i),
      .b_i   (opb_i),
      .op_i  (op_sel_i),
      .res_o (logic_res)
   );

   always_comb begin
      if (ctrl.is_arith)      result_o = add_sum;
      else if (ctrl.is_logic) result_o = logic_res;
      else                    result_o = '0;
      wr_en_o = ctrl.wr_en;
      update  = ctrl.is_cmp | (set_flags_i & (ctrl.is_arith | ctrl.is_logic));
   end

   dpalu_flags #(
      .WIDTH      (WIDTH),
      .ZERO_TREE  (ZERO_TREE),
      .ZERO_CHUNK (ZERO_CHUNK)
   ) u_flags (
      .res_i         (result_o),
      .update_i      (update),
      .arith_i       (ctrl.is_arith),
      .cout_i        (add_cout),
      .ovf_i         (add_ovf),
      .shift_carry_i (shift_carry_i),
      .flags_i       (flags_i),
      .flags_o       (flags_o)
   );

   always_comb begin
      if (!$isunknown(op_sel_i)) begin
         AST_CMP_NO_WRITE: assert (!(ctrl.is_cmp && wr_en_o)); // R6
         AST_RSVD_QUIET: assert (!(op_sel_i >= 4'd13) || (!wr_en_o && result_o == '0 && flags_o == flags_i)); // R11
         AST_FLAG_HOLD: assert (ctrl.is_cmp || set_flags_i || flags_o == flags_i); // R7
         AST_LOGIC_V_KEEP: assert (!ctrl.is_logic || flags_o[FLAG_V] == flags_i[FLAG_V]); // R10
         AST_NZ_TRACK: assert (!update || (flags_o[FLAG_N] == result_o[MSB] && flags_o[FLAG_Z] == (result_o == '0))); // R8
      end
   end
endmodule

// File: tb/dpalu_tb.sv
module dpalu_top_tb_top;
   typedef struct packed {
      logic [7:0]  req;
      logic [3:0]  op;
      logic [31:0] a;
      logic [31:0] b;
      logic [3:0]  fi;
      logic        shc;
      logic        sf;
      logic [31:0] res;
      logic        we;
      logic [3:0]  fo;
   } vec_t;

   localparam int NV = 22;
   // fields: req, op, a, b, flags_in, shift_carry, set_flags, result, wr_en, flags_out
   localparam vec_t VECS [NV] = '{
      '{8'd1,  4'd3,  32'd1,          32'd2,          4'h0, 1'b0, 1'b1, 32'd3,          1'b1, 4'h0}, // R1 add
      '{8'd9,  4'd3,  32'h7FFFFFFF,   32'd1,          4'h0, 1'b0, 1'b1, 32'h80000000,   1'b1, 4'h9}, // R9 signed overflow
      '{8'd9,  4'd3,  32'hFFFFFFFF,   32'd1,          4'h0, 1'b0, 1'b1, 32'h0,          1'b1, 4'h6}, // R9 carry out, zero
      '{8'd1,  4'd4,  32'd5,          32'd6,          4'h2, 1'b0, 1'b1, 32'd12,         1'b1, 4'h0}, // R1 add with carry
      '{8'd2,  4'd5,  32'd10,         32'd3,          4'h2, 1'b0, 1'b1, 32'd7,          1'b1, 4'h2}, // R2 C set
      '{8'd2,  4'd5,  32'd10,         32'd3,          4'h0, 1'b0, 1'b1, 32'd6,          1'b1, 4'h2}, // R2 C clear
      '{8'd2,  4'd5,  32'd3,          32'd10,         4'h2, 1'b0, 1'b1, 32'hFFFFFFF9,   1'b1, 4'h8}, // R2 borrow
      '{8'd3,  4'd2,  32'd3,          32'd10,         4'h0, 1'b0, 1'b1, 32'd7,          1'b1, 4'h2}, // R3 reverse sub
      '{8'd3,  4'd6,  32'd3,          32'd10,         4'h0, 1'b0, 1'b1, 32'd6,          1'b1, 4'h2}, // R3 reverse sub carry
      '{8'd6,  4'd7,  32'd5,          32'd5,          4'h0, 1'b0, 1'b0, 32'h0,          1'b0, 4'h6}, // R6 compare equal
      '{8'd6,  4'd8,  32'h80000000,   32'h80000000,   4'h0, 1'b0, 1'b0, 32'h0,          1'b0, 4'h7}, // R6 compare negative
      '{8'd4,  4'd0,  32'h0000F0F0,   32'h0000FF00,   4'h1, 1'b1, 1'b1, 32'h0000F000,   1'b1, 4'h3}, // R4 and
      '{8'd4,  4'd9,  32'h000000F0,   32'h0000000F,   4'h0, 1'b0, 1'b1, 32'h000000FF,   1'b1, 4'h0}, // R4 or
      '{8'd4,  4'd1,  32'h0000FFFF,   32'h0000FFFF,   4'h0, 1'b1, 1'b1, 32'h0,          1'b1, 4'h6}, // R4 xor
      '{8'd4,  4'd11, 32'h000000FF,   32'h0000000F,   4'hA, 1'b0, 1'b0, 32'h000000F0,   1'b1, 4'hA}, // R4 bit clear
      '{8'd5,  4'd10, 32'h0,          32'h80000000,   4'h0, 1'b0, 1'b1, 32'h80000000,   1'b1, 4'h8}, // R5 move
      '{8'd5,  4'd12, 32'h0,          32'h0,          4'h1, 1'b1, 1'b1, 32'hFFFFFFFF,   1'b1, 4'hB}, // R5 move-not
      '{8'd7,  4'd3,  32'd1,          32'd2,          4'hF, 1'b0, 1'b0, 32'd3,          1'b1, 4'hF}, // R7 hold
      '{8'd11, 4'd13, 32'd1,          32'd2,          4'h5, 1'b0, 1'b1, 32'h0,          1'b0, 4'h5}, // R11 reserved
      '{8'd6,  4'd7,  32'd3,          32'd10,         4'h0, 1'b0, 1'b0, 32'hFFFFFFF9,   1'b0, 4'h8}, // R6 compare less
      '{8'd9,  4'd5,  32'h80000000,   32'd1,          4'h2, 1'b0, 1'b1, 32'h7FFFFFFF,   1'b1, 4'h3}, // R9 sub overflow
      '{8'd10, 4'd10, 32'h0,          32'd5,          4'h1, 1'b1, 1'b1, 32'd5,          1'b1, 4'h3}  // R10 shifter carry
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] opa, opb, result;
   logic [3:0]  flags_in, op_sel, flags_out;
   logic        shc, sf, wr_en;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   dpalu_top dut_i (
      .opa_i         (opa),
      .opb_i         (opb),
      .flags_i       (flags_in),
      .shift_carry_i (shc),
      .op_sel_i      (op_sel),
      .set_flags_i   (sf),
      .result_o      (result),
      .wr_en_o       (wr_en),
      .flags_o       (flags_out)
   );

   task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [3:0] fi, input logic sh, input logic s);
      @(posedge clk);
      #1;
      op_sel = op; opa = a; opb = b; flags_in = fi; shc = sh; sf = s;
      @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [31:0] er, input logic ew, input logic [3:0] ef);
      checks++;
      if (result !== er || wr_en !== ew || flags_out !== ef) begin
         errors++;
         $display("FAIL %s: got res=%h we=%b flags=%h, expected res=%h we=%b flags=%h",
                  tag, result, wr_en, flags_out, er, ew, ef);
      end
   endtask

   initial begin
      op_sel = 4'd0; opa = '0; opb = '0; flags_in = '0; shc = 1'b0; sf = 1'b0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // R12 reset-time idle state: AND of zeros, no update
      @(negedge clk);
      check("R12 idle after reset", 32'h0, 1'b1, 4'h0);

      foreach (VECS[i]) begin
         apply(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].fi, VECS[i].shc, VECS[i].sf);
         check($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].res, VECS[i].we, VECS[i].fo);
      end

      // R12 / R11 / R7: every code with flag enable low
      for (int k = 0; k < 16; k++) begin
         logic       ew;
         logic [3:0] ef;
         ew = (k <= 12) && (k != 7) && (k != 8);
         ef = (k == 7) ? 4'h6 : (k == 8) ? 4'h0 : 4'hC;
         apply(k[3:0], 32'h1234, 32'h1234, 4'hC, 1'b0, 1'b0);
         checks++;
         if (wr_en !== ew || flags_out !== ef) begin
            errors++;
            $display("FAIL R12 code %0d: got we=%b flags=%h, expected we=%b flags=%h",
                     k, wr_en, flags_out, ew, ef);
         end
      end

      // R8 walking one through the zero detector and N bit
      for (int k = 0; k < 32; k++) begin
         apply(4'd9, 32'd1 << k, 32'h0, 4'h0, 1'b0, 1'b1);
         check($sformatf("R8 walk bit %0d", k), 32'd1 << k, 1'b1, {(k == 31), 3'b000});
      end
      apply(4'd9, 32'h0, 32'h0, 4'h0, 1'b0, 1'b1);
      check("R8 all zero", 32'h0, 1'b1, 4'h4);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule